// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches twenty external input lines and turns selected transitions on them into requests for the rest of the chip. Each line has its own transition detector. Software picks rising edges, falling edges or both for each line. A detected transition can be recorded as a latched interrupt request, and it can also produce a single-cycle event strobe. Each of these two outputs has its own per-line enable mask. Software can also raise a request on any line by writing a register.

Transitions are captured by flops clocked directly by the input line. The captured state then crosses into the bus clock domain through a synchronizer chain. Because of this, a pulse much narrower than one bus clock period is still seen. A plain register bus does the setup. The bus is a single-cycle write strobe with a combinational read mux, and the same bus clears latched requests. The block drives one aggregated interrupt line and one event strobe per input line.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and all `evt_o` bits are low. The register addresses are: 0 interrupt enable, 1 event enable, 2 rising select, 3 falling select, 4 software request, 5 latched requests. Bit i of each register belongs to line i.
- R2: A rising transition on a line whose rising select and interrupt enable bits are both 1 sets that line's latched request bit within six clock cycles. `irq_o` is high while any latched request bit is 1.
- R3: A falling transition is detected only when the line's falling select bit is 1. A rising transition is detected only when its rising select bit is 1. An unselected transition leaves the latched request bits unchanged.
- R4: A line whose interrupt enable bit is 0 never sets its latched request bit, and it leaves `irq_o` low.
- R5: Writing 1 to a latched request bit clears it, and writing 0 leaves it unchanged. If a detected transition on a line is accepted in the same cycle as a clear of that line, the bit stays set.
- R6: When a line's event enable bit is 1, each detected transition drives that line's `evt_o` bit high for exactly one clock cycle. This happens whatever the interrupt enable bit is. With event enable 0, the `evt_o` bit stays low.
- R7: When both select bits of a line are 1, a rising transition and a later falling transition each set the latched request bit.
- R8: A high pulse on a line shorter than one clock period is detected as a rising transition.
- R9: Writing 1 to a software request bit that is 0 raises a request on that line, exactly like a detected transition. That bit then reads 1 until the line's latched request bit is cleared by a write, and after that it reads 0.
- R10: Lines are independent. A transition on one line changes no other line's latched request bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 20 | External request lines, sampled asynchronously |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 20 | Write data, bit i for line i |
| bus_rdata_o | output | 20 | Read data of the addressed register (combinational) |
| evt_o | output | 20 | Per-line single-cycle event strobes |
| irq_o | output | 1 | High while any latched request bit is set |

## Verification
The bench places a pending-clear write in exactly the cycle where a synchronized edge is accepted. A design that gives the clear priority would lose that request. It sends a pulse of a few nanoseconds, which a design that samples the line with the clock would miss entirely. It counts the cycles an event strobe stays high, to catch a strobe that is stretched or repeated. It also checks that the software request bit stays set until the latched bit is cleared and then drops; a wrong design would leave it stuck or clear it at once. Edges on unselected polarities, on masked lines and on neighbouring lines must leave the latched register unchanged.

// File: rtl/irq_evt_pkg.sv
// Package: register addresses and bus geometry shared by the controller,
// its submodules and its checker.
package irq_evt_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_IMASK  = 3'd0,
        A_EMASK  = 3'd1,
        A_RISE   = 3'd2,
        A_FALL   = 3'd3,
        A_SWTRIG = 3'd4,
        A_PEND   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/irq_evt_edge_sync.sv
// One line's transition capture. Two toggle flops are clocked by the
// line itself: one by its rising transitions, one by its falling
// transitions. Any transition, however short, therefore flips a toggle.
// Each toggle passes through STAGES synchronizer flops plus one history
// flop. A difference between the last two flops gives a one-cycle hit.
// Assumes: cap_rst_n is a bus-domain copy of reset, used only as the
// asynchronous clear of the toggles. Transitions on one polarity are
// spaced more than STAGES+1 clocks apart.
module irq_evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_rst_n,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic             rise_tgl, fall_tgl;
    logic [DEPTH-1:0] rise_sh, fall_sh;

    // Flip on each rising transition of the line.
    always_ff @(posedge line_i or negedge cap_rst_n) begin
        if (!cap_rst_n) rise_tgl <= 1'b0;
        else            rise_tgl <= ~rise_tgl;
    end

    // Flip on each falling transition of the line.
    always_ff @(negedge line_i or negedge cap_rst_n) begin
        if (!cap_rst_n) fall_tgl <= 1'b0;
        else            fall_tgl <= ~fall_tgl;
    end

    // Move both toggles into the bus clock domain and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_sh <= '0;
            fall_sh <= '0;
        end else begin
            rise_sh <= {rise_sh[DEPTH-2:0], rise_tgl};
            fall_sh <= {fall_sh[DEPTH-2:0], fall_tgl};
        end
    end

    assign rise_o = rise_sh[DEPTH-1] ^ rise_sh[DEPTH-2];
    assign fall_o = fall_sh[DEPTH-1] ^ fall_sh[DEPTH-2];
endmodule

// File: rtl/irq_evt_regs.sv
// Configuration registers and the software request register, with the
// read mux. Turns bus writes into a per-line software request strobe and
// a per-line clear vector for the latched requests.
// Assumes: a write is a one-cycle strobe; reads are combinational.
module irq_evt_regs
    import irq_evt_pkg::*;
#(
    parameter int NLINES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NLINES-1:0] wdata_i,
    input  logic [NLINES-1:0] pending_i,
    output logic [NLINES-1:0] imask_o,
    output logic [NLINES-1:0] emask_o,
    output logic [NLINES-1:0] rise_en_o,
    output logic [NLINES-1:0] fall_en_o,
    output logic [NLINES-1:0] swtrig_o,
    output logic [NLINES-1:0] sw_req_o,
    output logic [NLINES-1:0] clr_o,
    output logic [NLINES-1:0] rdata_o
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr_i);

    // Software request: only a 0 -> 1 write of a request bit counts.
    assign sw_req_o = (we_i && sel == A_SWTRIG) ? (wdata_i & ~swtrig_o) : '0;
    // Clear vector: a 1 written to the latched register clears that bit.
    assign clr_o    = (we_i && sel == A_PEND) ? wdata_i : '0;

    // Hold the four configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_o   <= '0;
            emask_o   <= '0;
            rise_en_o <= '0;
            fall_en_o <= '0;
        end else if (we_i) begin
            case (sel)
                A_IMASK: imask_o   <= wdata_i;
                A_EMASK: emask_o   <= wdata_i;
                A_RISE:  rise_en_o <= wdata_i;
                A_FALL:  fall_en_o <= wdata_i;
                default: ;
            endcase
        end
    end

    // Software request bits: set by a write, dropped when the line is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) swtrig_o <= '0;
        else        swtrig_o <= (swtrig_o | sw_req_o) & ~clr_o;
    end

    // Read mux; unused addresses read zero.
    always_comb begin
        case (sel)
            A_IMASK:  rdata_o = imask_o;
            A_EMASK:  rdata_o = emask_o;
            A_RISE:   rdata_o = rise_en_o;
            A_FALL:   rdata_o = fall_en_o;
            A_SWTRIG: rdata_o = swtrig_o;
            A_PEND:   rdata_o = pending_i;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_evt_pend.sv
// Latched request register and event strobe register. A hit on an
// interrupt-enabled line sets its latched bit, and a set wins over a
// clear in the same cycle. A hit on an event-enabled line gives a
// one-cycle strobe.
// Assumes: hit_i is high for one cycle per request.
module irq_evt_pend #(
    parameter int NLINES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] hit_i,
    input  logic [NLINES-1:0] imask_i,
    input  logic [NLINES-1:0] emask_i,
    input  logic [NLINES-1:0] clr_i,
    output logic [NLINES-1:0] pending_o,
    output logic [NLINES-1:0] evt_o
);
    // Latch requests; a new request overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_o <= '0;
        else        pending_o <= (pending_o & ~clr_i) | (hit_i & imask_i);
    end

    // Register the event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_o <= '0;
        else        evt_o <= hit_i & emask_i;
    end
endmodule

// File: rtl/irq_evt_ctrl.sv
// Top level of the interrupt and event line controller. It holds one
// transition capture per line, combines captured transitions with the
// enabled polarity and with software requests, and feeds the latched
// request and event logic.
// Assumes: clk is the bus clock and rst_n is synchronous, active low,
// held for at least two cycles.
module irq_evt_ctrl
    import irq_evt_pkg::*;
#(
    parameter int NLINES      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NLINES-1:0] bus_wdata_i,
    output logic [NLINES-1:0] bus_rdata_o,
    output logic [NLINES-1:0] evt_o,
    output logic              irq_o
);
    logic              cap_rst_n;
    logic [NLINES-1:0] rise_raw, fall_raw, edge_hit, hit;
    logic [NLINES-1:0] imask, emask, rise_en, fall_en, swtrig, sw_req, clr, pending;

    // Bus-domain copy of reset for clearing the line-clocked toggles.
    always_ff @(posedge clk) begin
        cap_rst_n <= rst_n;
    end

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
        irq_evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_rst_n (cap_rst_n),
            .line_i    (line_i[gi]),
            .rise_o    (rise_raw[gi]),
            .fall_o    (fall_raw[gi])
        );
    end

    assign edge_hit = (rise_raw & rise_en) | (fall_raw & fall_en);
    assign hit      = edge_hit | sw_req;
    assign irq_o    = |pending;

    irq_evt_regs #(.NLINES(NLINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .pending_i (pending),
        .imask_o   (imask),
        .emask_o   (emask),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en),
        .swtrig_o  (swtrig),
        .sw_req_o  (sw_req),
        .clr_o     (clr),
        .rdata_o   (bus_rdata_o)
    );

    irq_evt_pend #(.NLINES(NLINES)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .imask_i   (imask),
        .emask_i   (emask),
        .clr_i     (clr),
        .pending_o (pending),
        .evt_o     (evt_o)
    );
endmodule

// File: rtl/irq_evt_ctrl_chk.sv
// Checker for irq_evt_ctrl, attached by the bind at the end of this file.
// It watches the bus, the combined hit vector and the register state.
module irq_evt_ctrl_chk
    import irq_evt_pkg::*;
#(
    parameter int NLINES = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [NLINES-1:0] wdata_i,
    input logic [NLINES-1:0] hit,
    input logic [NLINES-1:0] pending,
    input logic [NLINES-1:0] imask,
    input logic [NLINES-1:0] emask,
    input logic [NLINES-1:0] swtrig,
    input logic [NLINES-1:0] evt_o,
    input logic              irq_o
);
    logic [NLINES-1:0] clr_w;
    assign clr_w = (we_i && addr_i == A_PEND) ? wdata_i : '0;

    // R2
    irq_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & imask)) |=> irq_o);

    // R4
    masked_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(imask)) == '0));

    // R5
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_PEND) |=> ((pending & $past(wdata_i) & ~$past(hit)) == '0));

    // R5
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pending) & ~pending & ~$past(clr_w)) == '0));

    // R6
    evt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((evt_o & ~$past(emask)) == '0));

    // R9
    swtrig_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(swtrig) & ~swtrig & ~$past(clr_w)) == '0));
endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .hit     (hit),
    .pending (pending),
    .imask   (imask),
    .emask   (emask),
    .swtrig  (swtrig),
    .evt_o   (evt_o),
    .irq_o   (irq_o)
);

// File: tb/irq_evt_ctrl_test.sv
// Directed bench for irq_evt_ctrl. Inputs change on falling clock edges;
// outputs are sampled there too.
module irq_evt_ctrl_test;
    localparam int N = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         we = 1'b0;
    logic [2:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] line = '0;
    logic [N-1:0] rdata, evt;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_evt_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .evt_o       (evt),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 register reset", 32'(d), 32'h0);
        end
        chk("R1 irq reset", 32'(irq), 32'h0);
        chk("R1 evt reset", 32'(evt), 32'h0);
    endtask

    task automatic t_rise();
        logic [N-1:0] d;
        wr(3'd0, N'(1) << 3);
        wr(3'd2, N'(1) << 3);
        @(negedge clk); line[3] = 1'b1;
        settle();
        rd(3'd5, d);
        chk("R2 rise sets pending / R10 others clear", 32'(d), 32'(N'(1) << 3));
        chk("R2 irq high", 32'(irq), 32'h1);
        wr(3'd5, N'(1) << 3);
        rd(3'd5, d);
        chk("R5 write one clears", 32'(d), 32'h0);
        chk("R2 irq low after clear", 32'(irq), 32'h0);
        @(negedge clk); line[3] = 1'b0;
        settle();
        rd(3'd5, d);
        chk("R3 unselected fall ignored", 32'(d), 32'h0);
    endtask

    task automatic t_fall();
        logic [N-1:0] d;
        wr(3'd0, (N'(1) << 3) | (N'(1) << 5));
        wr(3'd3, N'(1) << 5);
        @(negedge clk); line[5] = 1'b1;
        settle();
        rd(3'd5, d);
        chk("R3 unselected rise ignored", 32'(d), 32'h0);
        @(negedge clk); line[5] = 1'b0;
        settle();
        rd(3'd5, d);
        chk("R3 fall sets pending", 32'(d), 32'(N'(1) << 5));
        wr(3'd5, N'(1) << 5);
    endtask

    task automatic t_both();
        logic [N-1:0] d;
        wr(3'd0, N'(1) << 7);
        wr(3'd2, N'(1) << 7);
        wr(3'd3, N'(1) << 7);
        @(negedge clk); line[7] = 1'b1;
        settle();
        rd(3'd5, d);
        chk("R7 both: rise sets", 32'(d), 32'(N'(1) << 7));
        wr(3'd5, N'(1) << 7);
        @(negedge clk); line[7] = 1'b0;
        settle();
        rd(3'd5, d);
        chk("R7 both: fall sets", 32'(d), 32'(N'(1) << 7));
        wr(3'd5, N'(1) << 7);
    endtask

    task automatic t_mask();
        logic [N-1:0] d;
        int cnt = 0;
        wr(3'd0, '0);
        wr(3'd1, '0);
        wr(3'd2, N'(1) << 9);
        @(negedge clk); line[9] = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (evt[9]) cnt++;
        end
        rd(3'd5, d);
        chk("R4 masked line no pending", 32'(d), 32'h0);
        chk("R4 masked line irq low", 32'(irq), 32'h0);
        chk("R6 event disabled no strobe", 32'(cnt), 32'h0);
    endtask

    task automatic t_event();
        logic [N-1:0] d;
        int cnt = 0;
        wr(3'd1, N'(1) << 11);
        wr(3'd2, N'(1) << 11);
        @(negedge clk); line[11] = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (evt[11]) cnt++;
        end
        chk("R6 single-cycle event", 32'(cnt), 32'h1);
        rd(3'd5, d);
        chk("R6 event without pending", 32'(d), 32'h0);
    endtask

    task automatic t_narrow();
        logic [N-1:0] d;
        wr(3'd0, N'(1) << 13);
        wr(3'd2, N'(1) << 13);
        @(negedge clk);
        line[13] = 1'b1;
        #3;
        line[13] = 1'b0;
        settle();
        rd(3'd5, d);
        chk("R8 narrow pulse caught", 32'(d), 32'(N'(1) << 13));
        wr(3'd5, N'(1) << 13);
    endtask

    task automatic t_sw();
        logic [N-1:0] d;
        int cnt = 0;
        wr(3'd0, N'(1) << 15);
        wr(3'd1, N'(1) << 15);
        @(negedge clk);
        we = 1'b1; addr = 3'd4; wdata = N'(1) << 15;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        if (evt[15]) cnt++;
        repeat (3) begin
            @(negedge clk);
            if (evt[15]) cnt++;
        end
        chk("R9 software event once", 32'(cnt), 32'h1);
        rd(3'd5, d);
        chk("R9 software sets pending", 32'(d), 32'(N'(1) << 15));
        rd(3'd4, d);
        chk("R9 request bit held", 32'(d), 32'(N'(1) << 15));
        wr(3'd5, '0);
        rd(3'd5, d);
        chk("R5 write zero no effect", 32'(d), 32'(N'(1) << 15));
        wr(3'd5, N'(1) << 15);
        rd(3'd5, d);
        chk("R9 pending cleared", 32'(d), 32'h0);
        rd(3'd4, d);
        chk("R9 request bit drops", 32'(d), 32'h0);
    endtask

    task automatic t_race();
        logic [N-1:0] d;
        wr(3'd0, N'(1) << 17);
        wr(3'd2, N'(1) << 17);
        @(negedge clk); line[17] = 1'b1;
        settle();
        @(negedge clk); line[17] = 1'b0;
        settle();
        rd(3'd5, d);
        chk("R5 race setup pending", 32'(d), 32'(N'(1) << 17));
        @(negedge clk); line[17] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        we = 1'b1; addr = 3'd5; wdata = N'(1) << 17;
        @(negedge clk);
        we = 1'b0; wdata = '0;
        rd(3'd5, d);
        chk("R5 set wins over clear", 32'(d), 32'(N'(1) << 17));
        wr(3'd5, N'(1) << 17);
        rd(3'd5, d);
        chk("R5 plain clear", 32'(d), 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_mask();
        t_event();
        t_narrow();
        t_sw();
        t_race();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule